// File: doc/BRIEF.md
# Multi-Mode Register File

A small word store of 64 entries, each entry carrying a 16-bit data field and a 4-bit control field that travel together. A static mode input, held stable while the block is out of reset, picks one of three behaviours. As a dual-port RAM, writes and reads carry their own addresses. As a FIFO, internal pointers supply both addresses, and full and empty flags are reported. In sort mode, writes land at the address the producer gives, and reads walk the store from entry 0 upward, wrapping from 63 back to 0.

Both request sides follow valid/ready rules. A write is accepted in a cycle where `wr_req` and `wr_ready` are both high. A read is accepted in a cycle where `rd_req` and `rd_ready` are both high. A request made while ready is low is dropped, not held, so a producer that wants it must keep asserting it. Ready is low only in FIFO mode: `wr_ready` falls while the FIFO is full and `rd_ready` falls while it is empty. The read-data output has no ready. The consumer must take each word in the cycle `rd_valid` is high.

One write and one read can be accepted in every cycle. Read data leaves through a two-register pipeline. Between valid words, `rd_data` and `rd_ctrl` hold the last word delivered.

Top module: `multimode_regfile`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` and `rd_ctrl` are 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: With mode 2'b00 (RAM), a read accepted in cycle n makes `rd_valid` high in cycle n+2 only. In that cycle `{rd_ctrl, rd_data}` carries the word last written to `rd_addr`.
- R3: In RAM mode, a read and a write to the same address in the same cycle return the word stored before that write.
- R4: With mode 2'b01 (FIFO), words are read out in the order they were accepted for writing.
- R5: In FIFO mode, `fifo_empty` is 1 exactly when zero words are held and `fifo_full` is 1 exactly when 64 are held. `wr_ready` equals the inverse of `fifo_full` and `rd_ready` equals the inverse of `fifo_empty`.
- R6: In FIFO mode, a write while full changes nothing, and a read while empty produces no `rd_valid`.
- R7: In FIFO mode, with the store neither full nor empty, a write and a read accepted in the same cycle leave the number of held words unchanged.
- R8: With mode 2'b10 (sort), a write stores at `wr_addr`, and `rd_addr` is ignored. Successive accepted reads return entries 0, 1, …, 63 and then 0 again.
- R9: Reads accepted in consecutive cycles produce `rd_valid` in the same number of consecutive cycles, one word per cycle.
- R10: Outside FIFO mode, both ready outputs stay 1, `fifo_empty` stays 1 and `fifo_full` stays 0. Mode 2'b11 behaves as RAM mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode, static: 00 RAM, 01 FIFO, 10 sort, 11 RAM |
| wr_req | input | 1 | Write request (valid) |
| wr_ready | output | 1 | Write side can accept |
| wr_addr | input | 6 | Write address (RAM and sort modes) |
| wr_data | input | 16 | Write data field |
| wr_ctrl | input | 4 | Write control field |
| rd_req | input | 1 | Read request (valid) |
| rd_ready | output | 1 | Read side can accept |
| rd_addr | input | 6 | Read address (RAM mode only) |
| rd_valid | output | 1 | Read word present on the outputs |
| rd_data | output | 16 | Read data field |
| rd_ctrl | output | 4 | Read control field |
| fifo_full | output | 1 | FIFO holds 64 words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
A read and a write can be accepted in the same cycle. In RAM and sort mode they can hit the same entry, which must yield the word stored before that write. In FIFO mode they can fall at the full or empty edge, where only one of them is accepted. A directed case provokes each collision: a same-address RAM access, and simultaneous FIFO traffic at a middle fill level. Random mixes of reads and writes in every mode add many more. A reference model in the bench judges each delivered word, each flag and each ready value.

// File: rtl/mmrf_pkg.sv
package mmrf_pkg;
  typedef enum logic [1:0] {
    MODE_RAM     = 2'b00,
    MODE_FIFO    = 2'b01,
    MODE_SORT    = 2'b10,
    MODE_RAM_ALT = 2'b11
  } rf_mode_e;
endpackage

// File: rtl/mmrf_addr_gen.sv
module mmrf_addr_gen
  import mmrf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rf_mode_e          mode,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_ready,
  output logic              rd_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_idx,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              fifo_full,
  output logic              fifo_empty
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   FULL_CNT = (ADDR_W + 1)'(DEPTH);

  logic [ADDR_W-1:0] wptr, rptr;
  logic [ADDR_W:0]   count;
  logic              is_fifo, is_sort;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + ADDR_W'(1);
  endfunction

  assign is_fifo    = (mode == MODE_FIFO);
  assign is_sort    = (mode == MODE_SORT);
  assign fifo_full  = (count == FULL_CNT);
  assign fifo_empty = (count == '0);

  assign wr_ready = !is_fifo || !fifo_full;
  assign rd_ready = !is_fifo || !fifo_empty;
  assign wr_en    = wr_req && wr_ready;
  assign rd_en    = rd_req && rd_ready;

  // the FIFO owns both addresses; sort owns only the read address
  assign wr_idx = is_fifo ? wptr : wr_addr;
  assign rd_idx = (is_fifo || is_sort) ? rptr : rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (is_fifo && wr_en) wptr <= bump(wptr);
      if ((is_fifo || is_sort) && rd_en) rptr <= bump(rptr);
      if (is_fifo) begin
        case ({wr_en, rd_en})
          2'b10:   count <= count + (ADDR_W + 1)'(1);
          2'b01:   count <= count - (ADDR_W + 1)'(1);
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmrf_store.sv
module mmrf_store #(
  parameter int WORD_W = 20,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  // sampled at the same edge as a colliding write, so the old word is taken
  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_idx];
  end
endmodule

// File: rtl/mmrf_read_pipe.sv
module mmrf_read_pipe #(
  parameter int WORD_W = 20,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] store_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic first_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_v <= 1'b0;
    else        first_v <= rd_en;
  end

  genvar g;
  for (g = 1; g < STAGES; g++) begin : g_stage
    logic              v_in, vq;
    logic [WORD_W-1:0] d_in, dq;
    if (g == 1) begin : g_head
      assign v_in = first_v;
      assign d_in = store_word;
    end else begin : g_body
      assign v_in = g_stage[g-1].vq;
      assign d_in = g_stage[g-1].dq;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vq <= 1'b0;
        dq <= '0;
      end else begin
        vq <= v_in;
        if (v_in) dq <= d_in;
      end
    end
  end

  assign out_valid = g_stage[STAGES-1].vq;
  assign out_word  = g_stage[STAGES-1].dq;
endmodule

// File: rtl/multimode_regfile.sv
module multimode_regfile
  import mmrf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 4,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_req,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              rd_req,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] rd_ctrl,
  output logic              fifo_full,
  output logic              fifo_empty
);
  localparam int WORD_W = DATA_W + CTRL_W;
  localparam int STAGES = 2;

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_idx, rd_idx;
  logic [WORD_W-1:0] store_word, out_word;

  mmrf_addr_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (rf_mode_e'(mode)),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .wr_ready   (wr_ready),
    .rd_ready   (rd_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
  );

  mmrf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word ({wr_ctrl, wr_data}),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_word (store_word)
  );

  mmrf_read_pipe #(.WORD_W(WORD_W), .STAGES(STAGES)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .store_word (store_word),
    .out_valid  (rd_valid),
    .out_word   (out_word)
  );

  assign {rd_ctrl, rd_data} = out_word;
endmodule

// File: rtl/multimode_regfile_chk.sv
module multimode_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       wr_req,
  input logic       wr_ready,
  input logic       rd_req,
  input logic       rd_ready,
  input logic       rd_valid,
  input logic       fifo_full,
  input logic       fifo_empty
);
  logic fire_d1, fire_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_d1 <= 1'b0;
      fire_d2 <= 1'b0;
    end else begin
      fire_d1 <= rd_req && rd_ready;
      fire_d2 <= fire_d1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == fire_d2); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R5

  AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_full) |-> $past(wr_req && wr_ready && !(rd_req && rd_ready))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !wr_ready); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && fifo_empty) |-> !rd_ready); // R6

  AST_BOTH_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && wr_req && wr_ready && rd_req && rd_ready)
      |=> ($stable(fifo_full) && $stable(fifo_empty))); // R7

  AST_OPEN_OUTSIDE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (wr_ready && rd_ready && fifo_empty && !fifo_full)); // R10
endmodule

bind multimode_regfile multimode_regfile_chk u_chk (.*);

// File: tb/multimode_regfile_test.sv
module multimode_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr_req = 1'b0, rd_req = 1'b0;
  logic        wr_ready, rd_ready, rd_valid, fifo_full, fifo_empty;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [3:0]  wr_ctrl = '0, rd_ctrl;

  always #10 clk = ~clk;

  multimode_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_req(wr_req), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ctrl(rd_ctrl),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  int nchk = 0, nerr = 0, nvalid = 0;
  bit done = 0;
  // reference model
  logic [19:0] mm [64];
  bit          mk [64];
  int          m_cnt, m_wp, m_rp, cur_mode;
  bit          m_v1, m_v2, m_k1, m_k2;
  logic [19:0] m_d1, m_d2, obs_d, last_d;
  logic        obs_v;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(input int i, input int salt);
    return 20'((i * 37 + salt * 1103) ^ (salt << 12));
  endfunction

  task automatic do_reset(input int md);
    @(negedge clk);
    rst_n = 1'b0; mode = 2'(md); cur_mode = md;
    wr_req = 0; rd_req = 0;
    repeat (3) @(negedge clk);
    m_cnt = 0; m_wp = 0; m_rp = 0;
    m_v1 = 0; m_v2 = 0; m_k1 = 0; m_k2 = 0;
    rst_n = 1'b1;
    #1;
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_word", {rd_ctrl, rd_data}, 0);
    check("R1 fifo_empty", fifo_empty, 1);
    check("R1 fifo_full", fifo_full, 0);
  endtask

  task automatic cyc(input bit wr, input int wa, input logic [19:0] wd,
                     input bit rd, input int ra);
    string tag;
    bit wacc, racc;
    int widx, ridx;
    @(negedge clk);
    case (cur_mode)
      1: tag = "R4 fifo";
      2: tag = "R8 sort";
      3: tag = "R10 alt";
      default: tag = "R2 ram";
    endcase
    obs_v = rd_valid; obs_d = {rd_ctrl, rd_data};
    if (rd_valid) begin nvalid++; last_d = obs_d; end
    check({tag, " valid"}, rd_valid, m_v2);
    if (m_v2 && m_k2) check({tag, " word"}, obs_d, m_d2);
    check("R5 full flag", fifo_full, (cur_mode == 1 && m_cnt == 64));
    check("R5 empty flag", fifo_empty, !(cur_mode == 1 && m_cnt != 0));
    check("R5 wr_ready", wr_ready, !(cur_mode == 1 && m_cnt == 64));
    check("R5 rd_ready", rd_ready, !(cur_mode == 1 && m_cnt == 0));
    wr_req = wr; wr_addr = 6'(wa); {wr_ctrl, wr_data} = wd;
    rd_req = rd; rd_addr = 6'(ra);
    wacc = wr && (cur_mode != 1 || m_cnt < 64);
    racc = rd && (cur_mode != 1 || m_cnt > 0);
    ridx = (cur_mode == 1 || cur_mode == 2) ? m_rp : ra;
    widx = (cur_mode == 1) ? m_wp : wa;
    m_v2 = m_v1; m_d2 = m_d1; m_k2 = m_k1;
    m_v1 = racc;
    if (racc) begin m_d1 = mm[ridx]; m_k1 = mk[ridx]; end
    if (wacc) begin mm[widx] = wd; mk[widx] = 1; end
    if (cur_mode == 1) begin
      if (wacc) m_wp = (m_wp + 1) % 64;
      m_cnt = m_cnt + int'(wacc) - int'(racc);
    end
    if ((cur_mode == 1 || cur_mode == 2) && racc) m_rp = (m_rp + 1) % 64;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic random_phase(input int n, input int wbias, input int rbias);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < wbias, $urandom % 64, 20'($urandom),
          ($urandom % 100) < rbias, $urandom % 64);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) mk[i] = 0;

    // RAM mode
    do_reset(0);
    for (int i = 0; i < 64; i++) cyc(1, i, pat(i, 1), 0, 0);
    cyc(0, 0, 0, 1, 17); idle(2);
    check("R2 read back addr 17", obs_d, pat(17, 1));
    cyc(1, 5, 20'h12345, 1, 5); idle(2);
    check("R3 same-address old word", obs_d, pat(5, 1));
    cyc(0, 0, 0, 1, 5); idle(2);
    check("R3 new word after collision", obs_d, 20'h12345);
    nvalid = 0;
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, i);
    idle(2);
    check("R9 back-to-back valid count", nvalid, 8);
    random_phase(300, 50, 50);
    idle(2);

    // FIFO mode
    do_reset(1);
    cyc(0, 0, 0, 1, 0); idle(2);
    check("R6 read while empty gives no valid", obs_v, 0);
    for (int i = 0; i < 64; i++) cyc(1, 0, pat(i, 2), 0, 0);
    idle(1);
    check("R5 full after 64 writes", fifo_full, 1);
    cyc(1, 0, 20'hABCDE, 0, 0);
    nvalid = 0;
    for (int i = 0; i < 66; i++) cyc(0, 0, 0, 1, 0);
    idle(2);
    check("R6 write while full ignored: count", nvalid, 64);
    check("R6 write while full ignored: last word", last_d, pat(63, 2));
    for (int i = 0; i < 3; i++) cyc(1, 0, pat(i, 3), 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 0, pat(i + 3, 3), 1, 0);
    idle(2);
    nvalid = 0;
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0);
    idle(2);
    check("R7 simultaneous traffic keeps level", nvalid, 3);
    random_phase(400, 60, 40);
    random_phase(400, 40, 60);
    idle(2);

    // sort mode
    do_reset(2);
    for (int i = 63; i >= 0; i--) cyc(1, i, pat(i, 4), 0, 0);
    for (int i = 0; i < 65; i++) cyc(0, 0, 0, 1, $urandom % 64);
    idle(2);
    check("R8 read pointer wraps to entry 0", last_d, pat(0, 4));
    cyc(0, 0, 0, 1, 0); idle(2);
    check("R8 next after wrap is entry 1", obs_d, pat(1, 4));
    random_phase(300, 50, 50);
    idle(2);

    // alternate RAM encoding
    do_reset(3);
    check("R10 ready outside fifo", {wr_ready, rd_ready}, 2'b11);
    cyc(1, 9, 20'h0F0F0, 0, 0);
    cyc(0, 0, 0, 1, 9); idle(2);
    check("R10 mode 3 acts as RAM", obs_d, 20'h0F0F0);
    random_phase(200, 50, 50);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule